// File: doc/BRIEF.md
# Sequence Trigger Handshake Engine

This block starts sequences in a peripheral's client register window and waits for each one to be acknowledged. A host pulses `start` with an 8-bit request bitmap. For every set bit, taken in turn, the engine arms the request and clears the response in the peripheral's registers, fires the software trigger, and then polls the response register. The poll ends on an acknowledge, a negative acknowledge (the response reads all ones), or a bounded timeout. The engine owns a simple single-master register bus. On that bus each transfer holds its request until the slave returns ready. Bit-level updates are done as read-modify-write.

The registers sit at fixed offsets from a base address parameter: trigger control at +0x42, request at +0x50 and response at +0x51. The spacing between polls is counted in clock cycles and set by a parameter, so a short value can be used in simulation. When a run ends, `done` pulses once and `err_code` holds the result until the next accepted start.

States: IDLE, ENTRY_RD (read the response register), ENTRY_CLR (wipe a stale all-ones response), SCAN (find the next set bit), RSP_CLR, REQ_SET, TRIG, POLL_RD, POLL_WAIT, NACK_CLR, REQ_DROP, RSP_DROP, FINAL (clear the whole bitmap in the request register). The transitions are as follows:
- IDLE→ENTRY_RD on a non-zero start.
- ENTRY_RD→ENTRY_CLR on all ones, otherwise →SCAN.
- ENTRY_CLR→SCAN.
- SCAN→RSP_CLR on a set bit, →FINAL past bit 7.
- RSP_CLR→REQ_SET→TRIG→POLL_RD.
- POLL_RD→NACK_CLR on all ones, →REQ_DROP on acknowledge, →FINAL on the last allowed miss, else →POLL_WAIT.
- POLL_WAIT→POLL_RD when the interval expires.
- NACK_CLR→FINAL.
- REQ_DROP→RSP_DROP→SCAN.
- FINAL→IDLE.
- Any bus error in a bus state →FINAL.

Top module: `seq_trig_engine`

## Requirements
- R1: Every bus transfer keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until a cycle with `bus_ready` high. A masked update is a read of the register followed by a write of (old & ~mask) | (value & mask) to the same address.
- R2: Take a start in idle with bitmap 0x00. One clock later `done`=1 and `err_code`=01 (invalid), with `busy` low, and no bus transfer occurs.
- R3: A run with a non-zero bitmap first reads the response register (base+0x51). If it reads 0xFF, a plain write of 0x00 to it follows before any other access.
- R4: Set bits are served one at a time from bit 0 up to bit 7. Clear bits cause no bus access.
- R5: For each served bit, three masked updates are made in this order: clear that bit in the response register, set it in the request register (base+0x50), then set bit 7 of the trigger control register (base+0x42).
- R6: After the trigger the response register is polled. A read with the served bit set is an acknowledge. It is followed by a masked clear of that bit in the request register and then in the response register.
- R7: A poll read of 0xFF is a negative acknowledge. The engine writes 0x00 to the response register and ends with `err_code`=10.
- R8: At most POLL_MAX polls are made per bit. More than POLL_GAP cycles pass between the completions of two polls. After POLL_MAX misses the run ends with `err_code`=11 and no further bit is served.
- R9: Every run with a non-zero bitmap ends with a masked clear of all bitmap bits in the request register. `done` is high for exactly one cycle after that. `err_code` is 00 on success.
- R10: A transfer completing with `bus_err` high stops the bit loop at once. The engine then goes to the final request clear and reports `err_code`=10.
- R11: A start pulse while `busy` is high is ignored, and the bus sequence of the running request is unchanged.
- R12: After reset `busy`, `done`, `err_code` and `bus_req` are all zero. `busy` is high from one clock after an accepted non-zero start until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| bitmap | input | DW | Sequence bits to trigger, sampled with start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| err_code | output | 2 | 00 none, 01 invalid, 10 nack or bus error, 11 timeout |
| bus_req | output | 1 | Transfer request, held until ready |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with ready |
| bus_ready | input | 1 | Transfer completes this cycle |
| bus_err | input | 1 | Transfer failed, valid with ready |

## Verification
An invalid start yields `done` and code 01 exactly one clock after the sampling edge. A valid start makes `busy` visible one clock after that edge, so the bench samples both at the falling edge right after the start cycle. Each bus transfer is compared against the head of a behaviourally built expectation queue at the falling edge where the bench's slave raises ready, which is the only cycle the transfer is final. Poll spacing is measured in cycles between the completions of poll reads. `done` is awaited at falling edges, the code is checked in the same sample, and the next falling edge must show `done` low again.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_RMW = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_INVALID = 2'd1,
        ERR_NACK    = 2'd2,
        ERR_TIMEOUT = 2'd3
    } err_code_e;

    // offsets from the window base; the peripheral decodes them
    localparam logic [7:0] OFS_CTL = 8'h42;
    localparam logic [7:0] OFS_REQ = 8'h50;
    localparam logic [7:0] OFS_RSP = 8'h51;
    localparam int         TRIG_BIT = 7;
    localparam logic [7:0] NACK_CODE = 8'hFF;
endpackage

// File: rtl/stq_gap_timer.sv
module stq_gap_timer #(
    parameter int GAP = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CW'(GAP);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == CW'(1));

    // R8
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expire || (GAP == 1));
endmodule

// File: rtl/stq_bus_port.sv
module stq_bus_port
    import seq_trig_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  op_kind_e      op_kind,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_mask,
    input  logic [DW-1:0] op_val,
    output logic          op_done,
    output logic          op_err,
    output logic [DW-1:0] op_rdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    input  logic          bus_err
);
    typedef enum logic [1:0] {P_IDLE, P_READ, P_WRITE} pstate_e;

    pstate_e       ps, ps_nx;
    logic          rmw_q;
    logic [DW-1:0] mask_q, val_q;

    always_comb begin
        ps_nx = ps;
        unique case (ps)
            P_IDLE:  if (op_start) ps_nx = (op_kind == OP_WR) ? P_WRITE : P_READ;
            P_READ:  if (bus_ready) ps_nx = (rmw_q && !bus_err) ? P_WRITE : P_IDLE;
            P_WRITE: if (bus_ready) ps_nx = P_IDLE;
            default: ps_nx = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps <= P_IDLE;
        else        ps <= ps_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_done   <= 1'b0;
            op_err    <= 1'b0;
            op_rdata  <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rmw_q     <= 1'b0;
            mask_q    <= '0;
            val_q     <= '0;
        end else begin
            op_done <= 1'b0;
            unique case (ps)
                P_IDLE: if (op_start) begin
                    bus_addr  <= op_addr;
                    bus_wdata <= op_val;
                    rmw_q     <= (op_kind == OP_RMW);
                    mask_q    <= op_mask;
                    val_q     <= op_val;
                    op_err    <= 1'b0;
                end
                P_READ: if (bus_ready) begin
                    op_rdata <= bus_rdata;
                    if (rmw_q && !bus_err) begin
                        bus_wdata <= (bus_rdata & ~mask_q) | (val_q & mask_q);
                    end else begin
                        op_done <= 1'b1;
                        op_err  <= bus_err;
                    end
                end
                P_WRITE: if (bus_ready) begin
                    op_done <= 1'b1;
                    op_err  <= bus_err;
                end
                default: ;
            endcase
        end
    end

    assign bus_req = (ps != P_IDLE);
    assign bus_we  = (ps == P_WRITE);

    // R1
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !bus_req);
endmodule

// File: rtl/seq_trig_engine.sv
module seq_trig_engine
    import seq_trig_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] BASE   = 'h1000,
    parameter int          POLL_MAX = 2000,
    parameter int          POLL_GAP = 50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] bitmap,
    output logic          busy,
    output logic          done,
    output logic [1:0]    err_code,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    input  logic          bus_err
);
    localparam int SW  = (DW > 1) ? $clog2(DW) : 1;
    localparam int IW  = $clog2(DW + 1);
    localparam int PCW = $clog2(POLL_MAX + 1);
    localparam logic [AW-1:0] A_CTL = BASE + AW'(OFS_CTL);
    localparam logic [AW-1:0] A_REQ = BASE + AW'(OFS_REQ);
    localparam logic [AW-1:0] A_RSP = BASE + AW'(OFS_RSP);
    localparam logic [DW-1:0] TRIG_MASK = DW'(1) << TRIG_BIT;

    typedef enum logic [3:0] {
        S_IDLE, S_ENTRY_RD, S_ENTRY_CLR, S_SCAN, S_RSP_CLR, S_REQ_SET, S_TRIG,
        S_POLL_RD, S_POLL_WAIT, S_NACK_CLR, S_REQ_DROP, S_RSP_DROP, S_FINAL
    } state_e;

    state_e        state, state_nx;
    logic          pend;
    logic [DW-1:0] bmap_q;
    logic [IW-1:0] idx;
    logic [PCW-1:0] polls;
    err_code_e     err_q;
    logic          done_q;

    logic          op_start, op_done, op_err, is_bus, tmr_load, tmr_exp;
    op_kind_e      op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_mask, op_val, op_rdata, cur_bit;
    logic [SW-1:0] idx_sel;
    logic          scan_end, poll_last;

    assign idx_sel   = idx[SW-1:0];
    assign cur_bit   = DW'(1) << idx_sel;
    assign scan_end  = (idx == IW'(DW));
    assign poll_last = (polls == PCW'(POLL_MAX - 1));
    assign is_bus    = !(state inside {S_IDLE, S_SCAN, S_POLL_WAIT});
    assign op_start  = is_bus && !pend;

    always_comb begin
        op_kind = OP_RMW;
        op_addr = A_RSP;
        op_mask = '0;
        op_val  = '0;
        unique case (state)
            S_ENTRY_RD, S_POLL_RD:   op_kind = OP_RD;
            S_ENTRY_CLR, S_NACK_CLR: op_kind = OP_WR;
            S_RSP_CLR, S_RSP_DROP:   op_mask = cur_bit;
            S_REQ_SET:  begin op_addr = A_REQ; op_mask = cur_bit;   op_val = cur_bit;   end
            S_TRIG:     begin op_addr = A_CTL; op_mask = TRIG_MASK; op_val = TRIG_MASK; end
            S_REQ_DROP: begin op_addr = A_REQ; op_mask = cur_bit;   end
            S_FINAL:    begin op_addr = A_REQ; op_mask = bmap_q;    end
            default: ;
        endcase
    end

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        unique case (state)
            S_IDLE:      if (start && bitmap != '0) state_nx = S_ENTRY_RD;
            S_ENTRY_RD:  if (op_done) state_nx = op_err ? S_FINAL :
                             (op_rdata == NACK_CODE) ? S_ENTRY_CLR : S_SCAN;
            S_ENTRY_CLR: if (op_done) state_nx = op_err ? S_FINAL : S_SCAN;
            S_SCAN:      if (scan_end) state_nx = S_FINAL;
                         else if (bmap_q[idx_sel]) state_nx = S_RSP_CLR;
            S_RSP_CLR:   if (op_done) state_nx = op_err ? S_FINAL : S_REQ_SET;
            S_REQ_SET:   if (op_done) state_nx = op_err ? S_FINAL : S_TRIG;
            S_TRIG:      if (op_done) state_nx = op_err ? S_FINAL : S_POLL_RD;
            S_POLL_RD:   if (op_done) begin
                             if (op_err)                       state_nx = S_FINAL;
                             else if (op_rdata == NACK_CODE)   state_nx = S_NACK_CLR;
                             else if (op_rdata[idx_sel])       state_nx = S_REQ_DROP;
                             else if (poll_last)               state_nx = S_FINAL;
                             else begin state_nx = S_POLL_WAIT; tmr_load = 1'b1; end
                         end
            S_POLL_WAIT: if (tmr_exp) state_nx = S_POLL_RD;
            S_NACK_CLR:  if (op_done) state_nx = S_FINAL;
            S_REQ_DROP:  if (op_done) state_nx = op_err ? S_FINAL : S_RSP_DROP;
            S_RSP_DROP:  if (op_done) state_nx = op_err ? S_FINAL : S_SCAN;
            S_FINAL:     if (op_done) state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            bmap_q <= '0;
            idx    <= '0;
            polls  <= '0;
            err_q  <= ERR_NONE;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (op_start) pend <= 1'b1;
            if (op_done)  pend <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    bmap_q <= bitmap;
                    idx    <= '0;
                    polls  <= '0;
                    if (bitmap == '0) begin
                        err_q  <= ERR_INVALID;
                        done_q <= 1'b1;
                    end else begin
                        err_q  <= ERR_NONE;
                    end
                end
                S_SCAN: if (!scan_end && !bmap_q[idx_sel]) idx <= idx + 1'b1;
                S_TRIG: if (op_done) begin
                    polls <= '0;
                    if (op_err) err_q <= ERR_NACK;
                end
                S_POLL_RD: if (op_done) begin
                    if (op_err) err_q <= ERR_NACK;
                    else if (op_rdata != NACK_CODE && !op_rdata[idx_sel]) begin
                        if (poll_last) err_q <= ERR_TIMEOUT;
                        else           polls <= polls + 1'b1;
                    end
                end
                S_NACK_CLR: if (op_done) err_q <= ERR_NACK;
                S_RSP_DROP: if (op_done) begin
                    if (op_err) err_q <= ERR_NACK;
                    else        idx <= idx + 1'b1;
                end
                S_FINAL: if (op_done) begin
                    done_q <= 1'b1;
                    if (op_err && err_q == ERR_NONE) err_q <= ERR_NACK;
                end
                default: if (op_done && op_err) err_q <= ERR_NACK;
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign err_code = err_q;

    stq_bus_port #(.AW(AW), .DW(DW)) u_port (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_mask(op_mask), .op_val(op_val),
        .op_done(op_done), .op_err(op_err), .op_rdata(op_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err)
    );

    stq_gap_timer #(.GAP(POLL_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .expire(tmr_exp)
    );

    // R2
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && bitmap == '0 |=> done && err_code == ERR_INVALID && !busy);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        polls < PCW'(POLL_MAX));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(bmap_q));
endmodule

// File: tb/seq_trig_engine_bench.sv
module seq_trig_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int POLL_MAX   = 6;
    localparam int POLL_GAP   = 4;
    localparam logic [15:0] BASE  = 16'h1000;
    localparam logic [15:0] A_CTL = BASE + 16'h42;
    localparam logic [15:0] A_REQ = BASE + 16'h50;
    localparam logic [15:0] A_RSP = BASE + 16'h51;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0]  bitmap = 8'h00;
    logic        busy, done, bus_req, bus_we;
    logic [1:0]  err_code;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'h00;
    logic        bus_ready = 1'b0, bus_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_trig_engine #(.AW(16), .DW(8), .BASE(BASE), .POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)) u_seq_trig_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .bitmap(bitmap),
        .busy(busy), .done(done), .err_code(err_code),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err)
    );

    int checks = 0, errors = 0;
    longint cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // peripheral model: index 0 answers the design, index 1 feeds the reference
    logic [7:0] p_ctl [2];
    logic [7:0] p_req [2];
    logic [7:0] p_rsp [2];
    bit         p_armed [2];
    int         p_left [2];
    int         p_txn [2];
    int         mode [8];   // 0 ack, 1 nack, 2 silent
    int         dly [8];
    int         err_at;

    bit         exp_we [$];
    logic [15:0] exp_addr [$];
    logic [7:0] exp_data [$];
    bit         exp_poll [$];
    string      exp_tag [$];
    longint     last_poll;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    function automatic int lowbit(input logic [7:0] v);
        int r = 0;
        for (int i = 7; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    task automatic p_access(input int k, input bit we, input logic [15:0] a, input logic [7:0] wd,
                            output logic [7:0] rd, output bit e);
        int b;
        e = (p_txn[k] == err_at);
        p_txn[k]++;
        rd = 8'h00;
        if (e) return;
        if (we) begin
            if (a == A_CTL) begin
                p_ctl[k] = wd;
                if (wd[7]) begin p_armed[k] = 1; p_left[k] = dly[lowbit(p_req[k])]; end
            end else if (a == A_REQ) p_req[k] = wd;
            else if (a == A_RSP)     p_rsp[k] = wd;
        end else begin
            if (a == A_RSP && p_armed[k]) begin
                b = lowbit(p_req[k]);
                if (p_left[k] > 0) p_left[k]--;
                else if (mode[b] != 2) begin
                    if (mode[b] == 0) p_rsp[k] = p_rsp[k] | 8'(1 << b);
                    else              p_rsp[k] = 8'hFF;
                    p_armed[k] = 0;
                    p_ctl[k][7] = 1'b0;
                end
            end
            if (a == A_CTL)      rd = p_ctl[k];
            else if (a == A_REQ) rd = p_req[k];
            else if (a == A_RSP) rd = p_rsp[k];
        end
    endtask

    task automatic r_rd(input logic [15:0] a, input bit poll, input string tag, output logic [7:0] v, output bit e);
        exp_we.push_back(0); exp_addr.push_back(a); exp_data.push_back(8'h00);
        exp_poll.push_back(poll); exp_tag.push_back(tag);
        p_access(1, 0, a, 8'h00, v, e);
    endtask

    task automatic r_wr(input logic [15:0] a, input logic [7:0] d, input string tag, output bit e);
        logic [7:0] v;
        exp_we.push_back(1); exp_addr.push_back(a); exp_data.push_back(d);
        exp_poll.push_back(0); exp_tag.push_back(tag);
        p_access(1, 1, a, d, v, e);
    endtask

    // R1: masked update is a read then a merged write
    task automatic r_rmw(input logic [15:0] a, input logic [7:0] m, input logic [7:0] val, input string tag, output bit e);
        logic [7:0] v;
        r_rd(a, 0, tag, v, e);
        if (!e) r_wr(a, (v & ~m) | (val & m), tag, e);
    endtask

    task automatic build(input logic [7:0] bm, output logic [1:0] ee);
        logic [7:0] v, bit_m;
        bit e, stop;
        int polls;
        ee = 2'd0; stop = 0; e = 0;
        if (bm == 8'h00) begin ee = 2'd1; return; end
        r_rd(A_RSP, 0, "R3", v, e);
        if (e) stop = 1;
        else if (v == 8'hFF) begin r_wr(A_RSP, 8'h00, "R3", e); if (e) stop = 1; end
        for (int b = 0; b < 8; b++) begin
            if (stop) break;
            if (!bm[b]) continue;
            bit_m = 8'(1 << b);
            r_rmw(A_RSP, bit_m, 8'h00, "R5", e); if (e) begin stop = 1; break; end
            r_rmw(A_REQ, bit_m, bit_m, "R5", e); if (e) begin stop = 1; break; end
            r_rmw(A_CTL, 8'h80, 8'h80, "R5", e); if (e) begin stop = 1; break; end
            polls = 0;
            forever begin
                r_rd(A_RSP, 1, "R6", v, e);
                if (e) begin stop = 1; break; end
                if (v == 8'hFF) begin r_wr(A_RSP, 8'h00, "R7", e); ee = 2'd2; stop = 1; break; end
                if (v[b]) break;
                polls++;
                if (polls == POLL_MAX) begin ee = 2'd3; stop = 1; break; end
            end
            if (stop) break;
            r_rmw(A_REQ, bit_m, 8'h00, "R6", e); if (e) begin stop = 1; break; end
            r_rmw(A_RSP, bit_m, 8'h00, "R6", e); if (e) begin stop = 1; break; end
        end
        if (e && ee == 2'd0) ee = 2'd2;
        r_rmw(A_REQ, bm, 8'h00, "R9", e);
        if (e && ee == 2'd0) ee = 2'd2;
    endtask

    // bus slave: answers with a rotating latency and compares each finished transfer
    initial begin
        int cnt = 0, lat = 0;
        logic [7:0] rd;
        bit e;
        forever begin
            @(negedge clk);
            if (bus_ready) begin
                bus_ready = 1'b0; bus_err = 1'b0; cnt = 0;
            end else if (bus_req) begin
                if (cnt >= lat) begin
                    if (exp_we.size() == 0) begin
                        chk(0, "R1", "unexpected transfer addr", int'(bus_addr), 0);
                    end else begin
                        chk(bus_we == exp_we[0], exp_tag[0], "direction", int'(bus_we), int'(exp_we[0]));
                        chk(bus_addr == exp_addr[0], exp_tag[0], "address", int'(bus_addr), int'(exp_addr[0]));
                        if (exp_we[0])
                            chk(bus_wdata == exp_data[0], exp_tag[0], "write data", int'(bus_wdata), int'(exp_data[0]));
                        if (exp_poll[0]) begin
                            if (last_poll >= 0)
                                chk(cyc - last_poll > POLL_GAP, "R8", "poll spacing", int'(cyc - last_poll), POLL_GAP + 1);
                            last_poll = cyc;
                        end
                        void'(exp_we.pop_front()); void'(exp_addr.pop_front()); void'(exp_data.pop_front());
                        void'(exp_poll.pop_front()); void'(exp_tag.pop_front());
                    end
                    p_access(0, bus_we, bus_addr, bus_wdata, rd, e);
                    bus_rdata = rd; bus_err = e; bus_ready = 1'b1;
                    lat = (lat + 1) % 3;
                end else cnt++;
            end
        end
    end

    task automatic run_case(input string rq, input logic [7:0] bm, input logic [7:0] rsp0, input int eat, input bit poke);
        logic [1:0] ee;
        int n;
        for (int k = 0; k < 2; k++) begin
            p_ctl[k] = 8'h00; p_req[k] = 8'h00; p_rsp[k] = rsp0;
            p_armed[k] = 0; p_left[k] = 0; p_txn[k] = 0;
        end
        err_at = eat;
        exp_we.delete(); exp_addr.delete(); exp_data.delete(); exp_poll.delete(); exp_tag.delete();
        last_poll = -1;
        build(bm, ee);
        p_txn[1] = 0;
        @(negedge clk); start = 1'b1; bitmap = bm;
        @(negedge clk); start = 1'b0;
        if (bm == 8'h00) begin
            chk(done == 1'b1 && busy == 1'b0, "R2", "done one clock after zero start", int'(done), 1);
        end else begin
            chk(busy == 1'b1, "R12", "busy after start", int'(busy), 1);
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; bitmap = 8'hFF;
            @(negedge clk); start = 1'b0; bitmap = 8'h00;
        end
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R9", "done seen", int'(done), 1);
        chk(err_code == ee, rq, "err_code", int'(err_code), int'(ee));
        chk(busy == 1'b0, "R12", "busy low at done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done is one cycle", int'(done), 0);
        chk(exp_we.size() == 0, poke ? "R11" : rq, "missing transfers", exp_we.size(), 0);
        if (bm == 8'h00) chk(p_txn[0] == 0, "R2", "bus untouched", p_txn[0], 0);
        else if (eat < 0) chk((p_req[0] & bm) == 8'h00, "R9", "request bits cleared", int'(p_req[0]), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_all(input int md, input int d);
        for (int i = 0; i < 8; i++) begin mode[i] = md; dly[i] = d; end
    endtask

    initial begin
        set_all(0, 0);
        err_at = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(busy == 0 && done == 0 && err_code == 0 && bus_req == 0, "R12", "reset outputs",
            int'({busy, done, err_code, bus_req}), 0);

        run_case("R2", 8'h00, 8'h00, -1, 0);

        set_all(0, 0);
        run_case("R5", 8'h01, 8'h10, -1, 0);

        set_all(0, 0); dly[0] = 1; dly[2] = 3; dly[7] = 2;
        run_case("R3", 8'hA5, 8'hFF, -1, 0);

        set_all(0, 0); mode[7] = 1; dly[7] = 2;
        run_case("R7", 8'h80, 8'h00, -1, 0);

        set_all(0, 0); mode[1] = 2;
        run_case("R8", 8'h06, 8'h00, -1, 0);

        set_all(0, 0);
        run_case("R10", 8'h03, 8'h00, 4, 0);

        set_all(0, 0); dly[0] = 4;
        run_case("R11", 8'h01, 8'h00, -1, 1);

        set_all(0, 0);
        run_case("R4", 8'hFF, 8'h00, -1, 0);

        set_all(0, 1);
        run_case("R4", 8'h48, 8'h22, -1, 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule